// File: doc/BRIEF.md
# Processor Control Register Unit

This unit keeps the processor's configuration state. That state covers the operand-width mode, the privilege flags, the feature flags and a pair of save registers filled on interrupt entry. Software reaches the unit through one port with a 3-bit register number, a write strobe, a write word and a combinational read word. Every write is checked before it is allowed to land. An illegal write leaves all state as it was and produces a one-cycle exception strobe with a 2-bit cause.

The mode is held one-hot, and the bit index is log2 of the operand width in bytes: bit 1 is 16-bit, bit 2 is 32-bit, bit 3 is 64-bit, bit 4 is 128-bit and bit 5 is 256-bit. The current mode and privilege are driven straight from their registers. A new value is therefore visible to the next instruction without any flush.

Privilege can only be given up through a direct write. New privilege bits are granted only by the interrupt-entry pulse, which ORs a grant mask into the privilege register. In the same cycle it saves the incoming instruction pointer and the old privilege value.

Top module: `cpu_ctrl_regs`

## Requirements
- R1: After reset, the mode is 32-bit (one-hot value 4), privilege is all ones, the optional feature state equals OPT_RESET, both save registers read zero, and no exception is signalled.
- R2: Reading register 0 returns the supported-mode mask SUP_MODES (default 6'b001110 for 16, 32 and 64 bits), not the current mode. cur_mode is always one-hot.
- R3: A write to register 0 whose word does not have exactly one bit set leaves the mode unchanged and raises cause 1 (bad mode).
- R4: A write to register 0 with one bit set outside SUP_MODES leaves the mode unchanged and raises cause 1.
- R5: A legal write to register 0 appears on cur_mode in the following cycle.
- R6: A write to register 1 (privilege) whose low PRIV_W bits only clear bits is stored and can be read back from register 1.
- R7: A write to register 1 that would set a bit that is currently clear leaves privilege unchanged and raises cause 2 (privilege escalation).
- R8: On irq_entry, register 4 takes cur_ip, register 5 takes the old privilege, and privilege becomes old privilege OR grant_mask. A write presented in the same cycle is dropped without an exception.
- R9: Reading register 2 returns FEAT_FIXED OR the enabled optional features. A write to it changes nothing and raises cause 3 (read-only).
- R10: Reading register 3 returns the configurable mask OPT_CFG. A write to it changes only the OPT_CFG bits of the optional feature state.
- R11: A write to register 4 or 5 changes nothing and raises cause 3.
- R12: exc_valid is high for exactly the cycle after each illegal write. exc_cause is 0 whenever exc_valid is low.
- R13: Registers 6 and 7 read zero, and writes to them have no effect and raise no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register number for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Write word |
| rd_data | output | XLEN | Read word for reg_sel, zero-extended |
| irq_entry | input | 1 | Interrupt-entry pulse |
| cur_ip | input | XLEN | Instruction pointer saved on interrupt entry |
| grant_mask | input | PRIV_W | Privileges granted on interrupt entry |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_cause | output | 2 | 1 bad mode, 2 privilege escalation, 3 read-only |
| cur_mode | output | MODE_W | Current one-hot mode |
| cur_priv | output | PRIV_W | Current privilege flags |

## Verification
The bench builds the unit with its defaults: a 32-bit word, a six-bit mode field supporting 16, 32 and 64 bits, eight privilege bits and sixteen feature bits, four of them configurable. With only three modes supported, bit 0 and bit 4 are one-hot yet unsupported, so the extra rejection path can be reached next to the plain not-one-hot cases. Setting the configurable mask apart from the fixed features lets an all-ones optional write show, through the feature read, exactly which bits were kept.

// File: rtl/cru_pkg.sv
package cru_pkg;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_PRIV  = 3'd1,
        SEL_FEAT  = 3'd2,
        SEL_OPT   = 3'd3,
        SEL_SIP   = 3'd4,
        SEL_SPRIV = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_BAD_MODE  = 2'd1,
        CAUSE_PRIV_UP   = 2'd2,
        CAUSE_READ_ONLY = 2'd3
    } cause_e;

endpackage

// File: rtl/cru_mode_guard.sv
// Decides whether a mode write word names exactly one supported mode.
module cru_mode_guard #(
    parameter int                XLEN      = 32,
    parameter int                MODE_W    = 6,
    parameter logic [MODE_W-1:0] SUP_MODES = 6'b001110
) (
    input  logic [XLEN-1:0] wr_word,
    output logic            legal
);
    localparam logic [XLEN-1:0] SUP_EXT = XLEN'(SUP_MODES);

    logic single_bit;
    logic inside_sup;

    always_comb begin
        single_bit = (wr_word != '0) && ((wr_word & (wr_word - 1'b1)) == '0);
        inside_sup = (wr_word & ~SUP_EXT) == '0;
        legal      = single_bit && inside_sup;
    end
endmodule

// File: rtl/cru_priv_guard.sv
// Flags a privilege write that would raise any flag currently clear.
module cru_priv_guard #(
    parameter int PRIV_W = 8
) (
    input  logic [PRIV_W-1:0] held,
    input  logic [PRIV_W-1:0] asked,
    output logic              raises
);
    always_comb raises = |(asked & ~held);
endmodule

// File: rtl/cru_read_mux.sv
module cru_read_mux
    import cru_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int PRIV_W = 8,
    parameter int FEAT_W = 16
) (
    input  logic [2:0]        sel,
    input  logic [XLEN-1:0]   sup_word,
    input  logic [PRIV_W-1:0] priv,
    input  logic [FEAT_W-1:0] feat_now,
    input  logic [FEAT_W-1:0] cfg_mask,
    input  logic [XLEN-1:0]   saved_ip,
    input  logic [PRIV_W-1:0] saved_priv,
    output logic [XLEN-1:0]   rd_word
);
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_MODE:  rd_word = sup_word;
            SEL_PRIV:  rd_word = XLEN'(priv);
            SEL_FEAT:  rd_word = XLEN'(feat_now);
            SEL_OPT:   rd_word = XLEN'(cfg_mask);
            SEL_SIP:   rd_word = saved_ip;
            SEL_SPRIV: rd_word = XLEN'(saved_priv);
            default:   rd_word = '0;
        endcase
    end
endmodule

// File: rtl/cpu_ctrl_regs.sv
module cpu_ctrl_regs
    import cru_pkg::*;
#(
    parameter int                XLEN       = 32,
    parameter int                MODE_W     = 6,
    parameter int                PRIV_W     = 8,
    parameter int                FEAT_W     = 16,
    parameter logic [MODE_W-1:0] SUP_MODES  = 6'b001110,
    parameter logic [MODE_W-1:0] RESET_MODE = 6'b000100,
    parameter logic [FEAT_W-1:0] FEAT_FIXED = 16'h0013,
    parameter logic [FEAT_W-1:0] OPT_CFG    = 16'h0F00,
    parameter logic [FEAT_W-1:0] OPT_RESET  = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   rd_data,
    input  logic              irq_entry,
    input  logic [XLEN-1:0]   cur_ip,
    input  logic [PRIV_W-1:0] grant_mask,
    output logic              exc_valid,
    output logic [1:0]        exc_cause,
    output logic [MODE_W-1:0] cur_mode,
    output logic [PRIV_W-1:0] cur_priv
);
    localparam logic [XLEN-1:0]   SUP_WORD  = XLEN'(SUP_MODES);
    localparam logic [FEAT_W-1:0] OPT_RST_M = OPT_RESET & OPT_CFG;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PRIV_W-1:0] priv;
        logic [FEAT_W-1:0] opt;
        logic [XLEN-1:0]   sip;
        logic [PRIV_W-1:0] spriv;
        logic              exc;
        cause_e            cause;
    } state_t;

    state_t st_q, st_d;

    logic mode_ok;
    logic priv_up;

    cru_mode_guard #(
        .XLEN(XLEN), .MODE_W(MODE_W), .SUP_MODES(SUP_MODES)
    ) u_mode_guard (
        .wr_word(wr_data),
        .legal  (mode_ok)
    );

    cru_priv_guard #(
        .PRIV_W(PRIV_W)
    ) u_priv_guard (
        .held  (st_q.priv),
        .asked (wr_data[PRIV_W-1:0]),
        .raises(priv_up)
    );

    cru_read_mux #(
        .XLEN(XLEN), .PRIV_W(PRIV_W), .FEAT_W(FEAT_W)
    ) u_read_mux (
        .sel       (reg_sel),
        .sup_word  (SUP_WORD),
        .priv      (st_q.priv),
        .feat_now  (FEAT_FIXED | st_q.opt),
        .cfg_mask  (OPT_CFG),
        .saved_ip  (st_q.sip),
        .saved_priv(st_q.spriv),
        .rd_word   (rd_data)
    );

    // Next-state: interrupt entry wins over any write in the same cycle.
    always_comb begin
        st_d       = st_q;
        st_d.exc   = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (irq_entry) begin
            st_d.sip   = cur_ip;
            st_d.spriv = st_q.priv;
            st_d.priv  = st_q.priv | grant_mask;
        end else if (wr_en) begin
            case (reg_sel)
                SEL_MODE: begin
                    if (mode_ok) begin
                        st_d.mode = wr_data[MODE_W-1:0];
                    end else begin
                        st_d.exc   = 1'b1;
                        st_d.cause = CAUSE_BAD_MODE;
                    end
                end
                SEL_PRIV: begin
                    if (priv_up) begin
                        st_d.exc   = 1'b1;
                        st_d.cause = CAUSE_PRIV_UP;
                    end else begin
                        st_d.priv = wr_data[PRIV_W-1:0];
                    end
                end
                SEL_OPT: begin
                    st_d.opt = (st_q.opt & ~OPT_CFG) | (wr_data[FEAT_W-1:0] & OPT_CFG);
                end
                SEL_FEAT, SEL_SIP, SEL_SPRIV: begin
                    st_d.exc   = 1'b1;
                    st_d.cause = CAUSE_READ_ONLY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= RESET_MODE;
            st_q.priv  <= '1;
            st_q.opt   <= OPT_RST_M;
            st_q.sip   <= '0;
            st_q.spriv <= '0;
            st_q.exc   <= 1'b0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_valid = st_q.exc;
    assign exc_cause = st_q.cause;
    assign cur_mode  = st_q.mode;
    assign cur_priv  = st_q.priv;
endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
    parameter int MODE_W = 6,
    parameter int PRIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              irq_entry,
    input logic [PRIV_W-1:0] grant_mask,
    input logic              exc_valid,
    input logic [1:0]        exc_cause,
    input logic [MODE_W-1:0] cur_mode,
    input logic [PRIV_W-1:0] cur_priv
);
    p_mode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cur_mode));

    p_bad_mode_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == 2'd1) |-> $stable(cur_mode));

    p_priv_no_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_entry |=> ((cur_priv & ~$past(cur_priv)) == '0));

    p_irq_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_entry |=> (cur_priv == ($past(cur_priv) | $past(grant_mask))));

    p_exc_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($past(wr_en) && !$past(irq_entry)));

    p_cause_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_cause == 2'd0));
endmodule

bind cpu_ctrl_regs cru_checker #(
    .MODE_W(MODE_W), .PRIV_W(PRIV_W)
) u_cru_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .irq_entry (irq_entry),
    .grant_mask(grant_mask),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .cur_mode  (cur_mode),
    .cur_priv  (cur_priv)
);

// File: tb/tb_cpu_ctrl_regs.sv
module tb_cpu_ctrl_regs;
    localparam int          XLEN   = 32;
    localparam int          MODE_W = 6;
    localparam int          PRIV_W = 8;
    localparam int          FEAT_W = 16;
    localparam logic [5:0]  SUP    = 6'b001110;
    localparam logic [5:0]  RMODE  = 6'b000100;
    localparam logic [15:0] FIXED  = 16'h0013;
    localparam logic [15:0] CFG    = 16'h0F00;
    localparam logic [15:0] ORST   = 16'h0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic              wr_en = 1'b0;
    logic [XLEN-1:0]   wr_data = '0;
    logic [XLEN-1:0]   rd_data;
    logic              irq_entry = 1'b0;
    logic [XLEN-1:0]   cur_ip = '0;
    logic [PRIV_W-1:0] grant_mask = '0;
    logic              exc_valid;
    logic [1:0]        exc_cause;
    logic [MODE_W-1:0] cur_mode;
    logic [PRIV_W-1:0] cur_priv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [5:0]  m_mode;
    logic [7:0]  m_priv;
    logic [15:0] m_opt;
    logic [31:0] m_sip;
    logic [7:0]  m_spriv;
    logic        m_exc;
    logic [1:0]  m_cause;

    always #10 clk = ~clk;

    cpu_ctrl_regs #(
        .XLEN(XLEN), .MODE_W(MODE_W), .PRIV_W(PRIV_W), .FEAT_W(FEAT_W),
        .SUP_MODES(SUP), .RESET_MODE(RMODE), .FEAT_FIXED(FIXED),
        .OPT_CFG(CFG), .OPT_RESET(ORST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_entry(irq_entry),
        .cur_ip(cur_ip), .grant_mask(grant_mask), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .cur_mode(cur_mode), .cur_priv(cur_priv)
    );

    function automatic logic [31:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return {26'd0, SUP};
            3'd1: return {24'd0, m_priv};
            3'd2: return {16'd0, FIXED | m_opt};
            3'd3: return {16'd0, CFG};
            3'd4: return m_sip;
            3'd5: return {24'd0, m_spriv};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input logic [2:0] s, input logic we,
                              input logic [31:0] wd, input logic irq,
                              input logic [31:0] ip, input logic [7:0] gm);
        m_exc   = 1'b0;
        m_cause = 2'd0;
        if (irq) begin
            m_sip   = ip;
            m_spriv = m_priv;
            m_priv  = m_priv | gm;
        end else if (we) begin
            if (s == 3'd0) begin
                if ($countones(wd) == 1 && (wd & ~{26'd0, SUP}) == 0) m_mode = wd[5:0];
                else begin m_exc = 1'b1; m_cause = 2'd1; end
            end else if (s == 3'd1) begin
                if ((wd[7:0] & ~m_priv) != 0) begin m_exc = 1'b1; m_cause = 2'd2; end
                else m_priv = wd[7:0];
            end else if (s == 3'd3) begin
                m_opt = (m_opt & ~CFG) | (wd[15:0] & CFG);
            end else if (s == 3'd2 || s == 3'd4 || s == 3'd5) begin
                m_exc = 1'b1; m_cause = 2'd3;
            end
        end
    endtask

    // One cycle: apply at negedge, check read, clock, check state.
    task automatic cyc(input string req, input logic [2:0] s, input logic we,
                       input logic [31:0] wd, input logic irq = 1'b0,
                       input logic [31:0] ip = 32'd0, input logic [7:0] gm = 8'd0);
        reg_sel = s; wr_en = we; wr_data = wd;
        irq_entry = irq; cur_ip = ip; grant_mask = gm;
        #1;
        check(req, "rd_data", rd_data, model_read(s));
        @(posedge clk);
        model_step(s, we, wd, irq, ip, gm);
        @(negedge clk);
        check(req, "cur_mode", {26'd0, cur_mode}, {26'd0, m_mode});
        check(req, "cur_priv", {24'd0, cur_priv}, {24'd0, m_priv});
        check(req, "exc", {29'd0, exc_valid, exc_cause}, {29'd0, m_exc, m_cause});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_mode = RMODE; m_priv = 8'hFF; m_opt = ORST & CFG;
        m_sip = '0; m_spriv = '0; m_exc = 1'b0; m_cause = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 supported-mode read, R9 R10 R13 reads
        cyc("R1", 3'd1, 1'b0, 32'd0);
        cyc("R2", 3'd0, 1'b0, 32'd0);
        cyc("R9", 3'd2, 1'b0, 32'd0);
        cyc("R10", 3'd3, 1'b0, 32'd0);
        cyc("R1", 3'd4, 1'b0, 32'd0);
        cyc("R1", 3'd5, 1'b0, 32'd0);
        cyc("R13", 3'd6, 1'b0, 32'd0);
        cyc("R13", 3'd7, 1'b0, 32'd0);
        // Mode writes
        cyc("R5", 3'd0, 1'b1, 32'd8);
        cyc("R3", 3'd0, 1'b1, 32'd0);
        cyc("R3", 3'd0, 1'b1, 32'd6);
        cyc("R3", 3'd0, 1'b1, 32'h0001_0004);
        cyc("R4", 3'd0, 1'b1, 32'd1);
        cyc("R4", 3'd0, 1'b1, 32'd16);
        cyc("R4", 3'd0, 1'b1, 32'h8000_0000);
        cyc("R5", 3'd0, 1'b1, 32'd2);
        cyc("R12", 3'd0, 1'b0, 32'd0);
        cyc("R5", 3'd0, 1'b1, 32'd4);
        // Privilege writes
        cyc("R6", 3'd1, 1'b1, 32'hF0);
        cyc("R7", 3'd1, 1'b1, 32'hF8);
        cyc("R7", 3'd1, 1'b1, 32'h01);
        cyc("R6", 3'd1, 1'b1, 32'h30);
        cyc("R6", 3'd1, 1'b0, 32'd0);
        // Feature and optional-feature
        cyc("R9", 3'd2, 1'b1, 32'hFFFF_FFFF);
        cyc("R9", 3'd2, 1'b0, 32'd0);
        cyc("R10", 3'd3, 1'b1, 32'hFFFF_FFFF);
        cyc("R10", 3'd2, 1'b0, 32'd0);
        cyc("R10", 3'd3, 1'b1, 32'h0000_0A00);
        cyc("R10", 3'd2, 1'b0, 32'd0);
        // Interrupt entry with a simultaneous write that must be dropped
        cyc("R8", 3'd1, 1'b1, 32'hFF, 1'b1, 32'h1234_5678, 8'h05);
        cyc("R8", 3'd4, 1'b0, 32'd0);
        cyc("R8", 3'd5, 1'b0, 32'd0);
        cyc("R8", 3'd0, 1'b1, 32'd0, 1'b1, 32'hCAFE_0000, 8'h00);
        cyc("R8", 3'd4, 1'b0, 32'd0);
        cyc("R8", 3'd5, 1'b0, 32'd0);
        // Save registers are read-only
        cyc("R11", 3'd4, 1'b1, 32'h0);
        cyc("R11", 3'd5, 1'b1, 32'hFF);
        cyc("R11", 3'd4, 1'b0, 32'd0);
        // Back-to-back illegal writes, then quiet
        cyc("R12", 3'd1, 1'b1, 32'hFF);
        cyc("R12", 3'd2, 1'b1, 32'h0);
        cyc("R12", 3'd3, 1'b0, 32'd0);
        // Unused numbers
        cyc("R13", 3'd6, 1'b1, 32'hFFFF_FFFF);
        cyc("R13", 3'd7, 1'b1, 32'hFFFF_FFFF);
        cyc("R13", 3'd6, 1'b0, 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule